// File: doc/BRIEF.md
# Rotor Lock Protection Timer

This block guards a three-phase motor drive against a stalled rotor. While the drive is active, a free-running tick counter measures how long the Hall code has gone without changing. Every Hall transition strobe restarts the count. If the count reaches a programmable limit, the block latches a fault that the output stage uses to hold the three high-side switches off. The block also issues a one-cycle expiry pulse that a reverse-rotation monitor can share.

The count does not run while the drive is braking, stopped, commanded to zero duty, not driving at all, or already faulted. Each of these conditions returns the count to zero, so a restart always gets a full window. The fault stays latched until one of two release conditions holds without a break for its own programmable number of cycles: stop, or zero duty. A protection-disable strap forces the fault clear and keeps the timer idle. Reset clears everything.

Top module: `rotor_lock_guard`

## Requirements
- R1: After reset, `hs_block` and `lock_expire` are both 0.
- R2: When `drive_en`=1 and `brake_req`, `stop_req`, `zero_duty`, `prot_off` and `hall_step` are all 0 for `lock_limit` consecutive clock edges, with no fault set, `hs_block` becomes 1 after the last of those edges. A `lock_limit` of 1 trips after a single such edge.
- R3: `lock_expire` is 1 for exactly the one cycle in which `hs_block` rises, and stays 0 otherwise.
- R4: A `hall_step`=1 sample restarts the count from zero. A strobe sampled on the edge that would have been the last tick of the window prevents the trip.
- R5: `brake_req`=1 holds the timer at zero, so it cannot trip. After brake is dropped, a full `lock_limit` window is needed.
- R6: `drive_en`=0, `stop_req`=1 or `zero_duty`=1 each hold the timer at zero in the same way.
- R7: Once set, `hs_block` stays 1 when drive conditions change, until a release condition is met. No further `lock_expire` pulse occurs while the fault is set.
- R8: `stop_req`=1 sampled on STOP_REL_TICKS consecutive edges clears `hs_block` after the last of them. A shorter run leaves the fault set.
- R9: `zero_duty`=1 sampled on ZD_REL_TICKS consecutive edges clears `hs_block` after the last of them. A shorter run leaves the fault set.
- R10: `prot_off`=1 clears `hs_block` after the next edge and suppresses any trip and any `lock_expire` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_step | input | 1 | One-cycle strobe on any Hall code change |
| drive_en | input | 1 | Motor drive is active |
| brake_req | input | 1 | Short-brake mode active |
| stop_req | input | 1 | Stop mode requested |
| zero_duty | input | 1 | Commanded output duty is zero |
| prot_off | input | 1 | Strap that disables the lock protection |
| lock_limit | input | CNT_W | Timeout in clock ticks |
| hs_block | output | 1 | Latched fault: high-side switches forced off |
| lock_expire | output | 1 | One-cycle pulse when the timer trips |

## Verification
Two events can land on the same edge: a Hall strobe and the final tick of the lock window. The bench runs the window to one tick short of the limit and then presents the strobe on the very edge that would have tripped. It expects no fault and no pulse, followed by a full fresh window before the trip. A second overlap is a fault release through stop while the drive request is still high. Here the bench expects the fault to clear and the timer to restart from zero rather than re-trip at once.

// File: rtl/rlg_pkg.sv
package rlg_pkg;

  typedef struct packed {
    logic hall;
    logic drive;
    logic brake;
    logic stop;
    logic zero;
    logic off;
  } rlg_ctrl_t;

  // Timer may run only while actively driving with no blocking condition.
  function automatic logic rlg_armed(rlg_ctrl_t c, logic fault);
    return c.drive & ~c.brake & ~c.stop & ~c.zero & ~c.off & ~fault;
  endfunction

endpackage

// File: rtl/rlg_lock_timer.sv
module rlg_lock_timer #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expire_now
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             last_tick;

  always_comb begin
    last_tick  = (cnt_q == (limit - CNT_W'(1)));
    expire_now = armed & ~restart & last_tick;
    if (!armed || restart || expire_now) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rlg_hold_qual.sv
module rlg_hold_qual #(
  parameter int unsigned TICKS = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic done
);

  localparam int unsigned HW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [HW-1:0] LAST = HW'(TICKS - 1);

  logic [HW-1:0] run_q;
  logic [HW-1:0] run_d;

  always_comb begin
    done = cond & (run_q == LAST);
    if (!cond) begin
      run_d = '0;
    end else if (done) begin
      run_d = run_q;
    end else begin
      run_d = run_q + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/rlg_fault_latch.sv
module rlg_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic release_ok,
  input  logic force_off,
  output logic fault_q,
  output logic pulse_q
);

  logic fault_d;
  logic pulse_d;

  always_comb begin
    pulse_d = trip & ~force_off;
    if (force_off || release_ok) begin
      fault_d = 1'b0;
    end else if (trip) begin
      fault_d = 1'b1;
    end else begin
      fault_d = fault_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      fault_q <= fault_d;
      pulse_q <= pulse_d;
    end
  end

endmodule

// File: rtl/rotor_lock_guard.sv
module rotor_lock_guard #(
  parameter int unsigned CNT_W          = 24,
  parameter int unsigned STOP_REL_TICKS = 2500,
  parameter int unsigned ZD_REL_TICKS   = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hall_step,
  input  logic             drive_en,
  input  logic             brake_req,
  input  logic             stop_req,
  input  logic             zero_duty,
  input  logic             prot_off,
  input  logic [CNT_W-1:0] lock_limit,
  output logic             hs_block,
  output logic             lock_expire
);
  import rlg_pkg::*;

  localparam int unsigned NREL = 2;
  localparam int unsigned HOLD [NREL] = '{STOP_REL_TICKS, ZD_REL_TICKS};

  rlg_ctrl_t        ctrl;
  logic             armed;
  logic             expire_now;
  logic [NREL-1:0]  rel_cond;
  logic [NREL-1:0]  rel_done;
  logic             fault_q;

  always_comb begin
    ctrl.hall  = hall_step;
    ctrl.drive = drive_en;
    ctrl.brake = brake_req;
    ctrl.stop  = stop_req;
    ctrl.zero  = zero_duty;
    ctrl.off   = prot_off;
    armed      = rlg_armed(ctrl, fault_q);
    rel_cond   = {ctrl.zero, ctrl.stop};
  end

  rlg_lock_timer #(.CNT_W(CNT_W)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .armed      (armed),
    .restart    (ctrl.hall),
    .limit      (lock_limit),
    .expire_now (expire_now)
  );

  for (genvar gi = 0; gi < NREL; gi++) begin : g_rel
    rlg_hold_qual #(.TICKS(HOLD[gi])) qual_i (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (rel_cond[gi]),
      .done  (rel_done[gi])
    );
  end

  rlg_fault_latch latch_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip       (expire_now),
    .release_ok (|rel_done),
    .force_off  (ctrl.off),
    .fault_q    (fault_q),
    .pulse_q    (lock_expire)
  );

  assign hs_block = fault_q;

endmodule

// File: rtl/rlg_checker.sv
module rlg_checker #(
  parameter int unsigned CNT_W          = 24,
  parameter int unsigned STOP_REL_TICKS = 2500
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hall_step,
  input logic             drive_en,
  input logic             brake_req,
  input logic             stop_req,
  input logic             zero_duty,
  input logic             prot_off,
  input logic [CNT_W-1:0] lock_limit,
  input logic             hs_block,
  input logic             lock_expire
);

  logic [31:0] stop_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_run_q <= '0;
    end else if (!stop_req) begin
      stop_run_q <= '0;
    end else if (stop_run_q != 32'hFFFF_FFFF) begin
      stop_run_q <= stop_run_q + 32'd1;
    end
  end

  // R3
  rise_has_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_block) |-> lock_expire);

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_expire |=> !lock_expire);

  // R4
  hall_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hall_step |=> !lock_expire);

  // R5
  brake_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brake_req |=> !lock_expire);

  // R6
  idle_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_en || stop_req || zero_duty) |=> !lock_expire);

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_run_q >= STOP_REL_TICKS) |-> !hs_block);

  // R10
  strap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_off |=> (!hs_block && !lock_expire));

  // R2
  limit_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> !$isunknown(lock_limit));

endmodule

bind rotor_lock_guard rlg_checker #(
  .CNT_W          (CNT_W),
  .STOP_REL_TICKS (STOP_REL_TICKS)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .hall_step   (hall_step),
  .drive_en    (drive_en),
  .brake_req   (brake_req),
  .stop_req    (stop_req),
  .zero_duty   (zero_duty),
  .prot_off    (prot_off),
  .lock_limit  (lock_limit),
  .hs_block    (hs_block),
  .lock_expire (lock_expire)
);

// File: tb/rotor_lock_guard_tb_top.sv
module rotor_lock_guard_tb_top;

  localparam int unsigned CNT_W = 8;
  localparam int unsigned STOP_T = 4;
  localparam int unsigned ZD_T = 6;

  typedef struct {
    logic  blk;
    logic  exp;
    string tag;
  } exp_t;

  logic clk;
  logic rst_n;
  logic hall_step, drive_en, brake_req, stop_req, zero_duty, prot_off;
  logic [CNT_W-1:0] lock_limit;
  logic hs_block, lock_expire;

  exp_t sb_q[$];
  int   checks;
  int   errors;
  bit   done;

  rotor_lock_guard #(
    .CNT_W(CNT_W), .STOP_REL_TICKS(STOP_T), .ZD_REL_TICKS(ZD_T)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .hall_step(hall_step), .drive_en(drive_en),
    .brake_req(brake_req), .stop_req(stop_req), .zero_duty(zero_duty),
    .prot_off(prot_off), .lock_limit(lock_limit),
    .hs_block(hs_block), .lock_expire(lock_expire)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Driver: apply one cycle of inputs and queue the outputs expected after the edge.
  task automatic drv(input logic h, input logic de, input logic br,
                     input logic st, input logic zd, input logic po,
                     input logic eb, input logic ee, input string tag);
    exp_t e;
    @(negedge clk);
    hall_step = h; drive_en = de; brake_req = br;
    stop_req = st; zero_duty = zd; prot_off = po;
    e.blk = eb; e.exp = ee; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic run(input int n, input logic de, input logic eb, input string tag);
    for (int i = 0; i < n; i++) drv(0, de, 0, 0, 0, 0, eb, 0, tag);
  endtask

  task automatic trip(input string tag);
    run(4, 1, 0, tag);
    drv(0, 1, 0, 0, 0, 0, 1, 1, tag);
  endtask

  task automatic stop_clear(input string tag);
    for (int i = 0; i < int'(STOP_T) - 1; i++) drv(0, 0, 0, 1, 0, 0, 1, 0, tag);
    drv(0, 0, 0, 1, 0, 0, 0, 0, tag);
  endtask

  // Monitor: pop and compare after every rising edge.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (hs_block !== e.blk || lock_expire !== e.exp) begin
        errors++;
        $display("FAIL %s: hs_block/lock_expire = %b%b expected %b%b",
                 e.tag, hs_block, lock_expire, e.blk, e.exp);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0;
    hall_step = 0; drive_en = 0; brake_req = 0;
    stop_req = 0; zero_duty = 0; prot_off = 0;
    lock_limit = 8'd5;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (hs_block !== 1'b0 || lock_expire !== 1'b0) begin
      errors++;
      $display("FAIL R1: outputs %b%b expected 00", hs_block, lock_expire);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 / R3: five undisturbed driven cycles trip; R7 latched, no repeat pulse
    trip("R2");
    run(3, 1, 1, "R7");
    run(2, 0, 1, "R7");
    // R8: stop held for the release window clears
    stop_clear("R8");

    // R4: strobe restarts the window
    run(3, 1, 0, "R4");
    drv(1, 1, 0, 0, 0, 0, 0, 0, "R4");
    run(4, 1, 0, "R4");
    drv(0, 1, 0, 0, 0, 0, 1, 1, "R4");
    stop_clear("R8");
    // R4: strobe on the final tick prevents the trip
    run(4, 1, 0, "R4");
    drv(1, 1, 0, 0, 0, 0, 0, 0, "R4");
    trip("R4");

    // R8: short stop run keeps fault
    for (int i = 0; i < int'(STOP_T) - 1; i++) drv(0, 0, 0, 1, 0, 0, 1, 0, "R8");
    drv(0, 0, 0, 0, 0, 0, 1, 0, "R8");
    // R9: short zero-duty run keeps fault, full run clears
    for (int i = 0; i < int'(ZD_T) - 1; i++) drv(0, 1, 0, 0, 1, 0, 1, 0, "R9");
    drv(0, 1, 0, 0, 0, 0, 1, 0, "R9");
    for (int i = 0; i < int'(ZD_T) - 1; i++) drv(0, 1, 0, 0, 1, 0, 1, 0, "R9");
    drv(0, 1, 0, 0, 1, 0, 0, 0, "R9");

    // R5: brake holds and restarts the window
    run(3, 1, 0, "R5");
    for (int i = 0; i < 8; i++) drv(0, 1, 1, 0, 0, 0, 0, 0, "R5");
    trip("R5");
    stop_clear("R8");

    // R6: drive drop, stop and zero duty each restart the window
    run(3, 1, 0, "R6");
    run(1, 0, 0, "R6");
    run(3, 1, 0, "R6");
    drv(0, 1, 0, 1, 0, 0, 0, 0, "R6");
    run(3, 1, 0, "R6");
    drv(0, 1, 0, 0, 1, 0, 0, 0, "R6");
    trip("R6");
    // release with stop while drive stays requested, then fresh window
    for (int i = 0; i < int'(STOP_T) - 1; i++) drv(0, 1, 0, 1, 0, 0, 1, 0, "R8");
    drv(0, 1, 0, 1, 0, 0, 0, 0, "R8");
    trip("R2");

    // R10: strap clears fault and blocks trips
    drv(0, 1, 0, 0, 0, 1, 0, 0, "R10");
    for (int i = 0; i < 10; i++) drv(0, 1, 0, 0, 0, 1, 0, 0, "R10");

    // R2 boundary: limit of one trips on a single driven edge
    lock_limit = 8'd1;
    drv(0, 1, 0, 0, 0, 0, 1, 1, "R2");
    drv(0, 1, 0, 0, 0, 0, 1, 0, "R7");
    stop_clear("R8");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule